// File: doc/BRIEF.md
# Stackable CAM Slice with Cascade Flag Chain

This block is one slice of a content-addressable memory that is meant to be stacked with identical slices. Each slice holds a small set of words, each with a valid bit. It compares a key against every valid word in parallel. It records whether any word matched and whether more than one matched. It also records the index of the lowest-numbered matching word, which has the highest priority inside the slice.

Two active-low chains link the slices. The match chain carries "a slice further up already matched" downward. Only the uppermost matching slice may then answer a highest-priority read or write, or a status read. The full chain carries "every slice further up is full" downward. A write-to-next-free command is then taken by exactly one slice: the first one that still has room. The host can insert and delete words without tracking free locations. An open-drain multiple-match output, modelled as an active-low flag, reports duplicates across the whole stack. Output drivers are modelled as output-enable bits.

A command is placed on `op`, `addr` and `din` while the active-low strobe `en_n` is held low. The command takes effect on the clock edge at which the strobe is seen high again. The first slice ties `match_in_n` high and `full_in_n` low. The `match_out_n` of the last slice is the system match indication.

Top module: `cam_stack_slice`

## Requirements
- R1: `match_out_n` is low exactly when `match_in_n` is low or the slice's stored local match flag (from the last compare, op 1) is set.
- R2: The local match flag, multiple flag and match index change only on the edge where `en_n` is seen high after being low. While `en_n` stays low they hold their values, even if the key changes.
- R3: `mmatch_out_n` is low when `match_in_n` is high and two or more entries matched, or when `match_in_n` is low and at least one entry matched. Otherwise it is high.
- R4: `maddr_oe` is high only when `match_in_n` is high and the local match flag is set. A highest-priority read (op 6) or status read (op 8) sets `rdata_oe` under the same condition, judged at the committing edge.
- R5: A write-to-next-free (op 3) is accepted only when `full_in_n` is low and the slice has a free entry. It then writes `din` into the lowest-numbered invalid entry and marks that entry valid. Otherwise it changes nothing.
- R6: `full_out_n` is low exactly when all entries are valid and `full_in_n` is low.
- R7: When several valid entries match, `maddr` carries the lowest matching index.
- R8: A write at highest-priority match (op 5) replaces the word at the stored match index only when `match_in_n` is high and the local match flag is set. Otherwise it has no effect.
- R9: A write at address (op 2) stores `din` at `addr` and marks it valid. A read at address (op 7) returns the word at `addr` with `rdata_oe` high. Both work whatever the state of `match_in_n`.
- R10: A delete (op 4) clears the valid bit at `addr`. An invalid entry never matches a compare.
- R11: A status read returns the local match flag in bit 0, the multiple flag in bit 1, the local full state in bit 2, and the match index starting at bit 3. All other bits are zero.
- R12: After reset all entries are invalid and both stored flags are clear. `rdata_oe` and `maddr_oe` are low, `full_out_n` is high, and `match_out_n` follows `match_in_n`.
- R13: Any other command (op 0 or unlisted codes) changes no entry. A non-read command drives `rdata_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Active-low command strobe; the command commits on its release |
| op | input | 4 | Command: 0 none, 1 compare, 2 write at address, 3 write next free, 4 delete, 5 write at match, 6 read at match, 7 read at address, 8 status read |
| addr | input | AW (4) | Entry index for address commands |
| din | input | WIDTH (32) | Compare key or write data |
| match_in_n | input | 1 | Match chain input, low when a slice above has matched |
| full_in_n | input | 1 | Full chain input, low when all slices above are full |
| match_out_n | output | 1 | Match chain output |
| full_out_n | output | 1 | Full chain output |
| mmatch_out_n | output | 1 | Multiple-match flag, active low |
| maddr | output | AW (4) | Index of the highest-priority local match |
| maddr_oe | output | 1 | Drive enable for `maddr` |
| rdata | output | WIDTH (32) | Read data |
| rdata_oe | output | 1 | Drive enable for `rdata` |

## Verification
The hardest case to reach is a duplicate key seen with the match chain in both states. Both matching entries must be valid, and the outcome differs by chain state. With `match_in_n` high, the multiple flag must assert and the slice must still answer. With `match_in_n` low, the same single local hit must raise the multiple flag, and the slice must go silent. The stimulus gets there in stages. It fills the slice through write-next-free, then plants a copy of an earlier word at a higher address with an address write. It then repeats the compare and the highest-priority accesses with `match_in_n` toggled. A delete followed by a write-next-free reopens a hole in the middle of the slice. This checks that the free pointer and the full chain recover.

// File: rtl/cam_slice_pkg.sv
package cam_slice_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_CMP     = 4'd1,
        OP_WR_AT   = 4'd2,
        OP_WR_FREE = 4'd3,
        OP_DEL     = 4'd4,
        OP_WR_HPM  = 4'd5,
        OP_RD_HPM  = 4'd6,
        OP_RD_AT   = 4'd7,
        OP_RD_STAT = 4'd8
    } cam_op_e;

    typedef struct packed {
        logic hit;
        logic multi;
    } cam_flags_t;

    function automatic cam_op_e decode_op(logic [3:0] code);
        case (code)
            4'd1:    return OP_CMP;
            4'd2:    return OP_WR_AT;
            4'd3:    return OP_WR_FREE;
            4'd4:    return OP_DEL;
            4'd5:    return OP_WR_HPM;
            4'd6:    return OP_RD_HPM;
            4'd7:    return OP_RD_AT;
            4'd8:    return OP_RD_STAT;
            default: return OP_NOP;
        endcase
    endfunction

    function automatic logic is_chain_gated(cam_op_e op);
        return (op == OP_WR_HPM) || (op == OP_RD_HPM) || (op == OP_RD_STAT);
    endfunction

endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 16,
    parameter int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [AW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    parameter int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic               clr_en,
    input  logic [AW-1:0]      clr_idx,
    input  logic [WIDTH-1:0]   key,
    input  logic [AW-1:0]      rd_idx,
    output logic [WIDTH-1:0]   rd_data,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [WIDTH-1:0] words [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_vec <= '0;
        end else begin
            if (clr_en) valid_vec[clr_idx] <= 1'b0;
            if (wr_en)  valid_vec[wr_idx]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_idx] <= wr_data;
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = valid_vec[g] && (words[g] == key);
        end
    endgenerate

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/cam_cascade.sv
module cam_cascade (
    input  logic match_in_n,
    input  logic full_in_n,
    input  logic local_hit,
    input  logic local_multi,
    input  logic local_full,
    output logic match_out_n,
    output logic full_out_n,
    output logic mmatch_out_n,
    output logic chain_owner,
    output logic free_owner
);
    logic upstream_hit;
    logic upstream_full;

    assign upstream_hit  = ~match_in_n;
    assign upstream_full = ~full_in_n;

    assign match_out_n  = ~(upstream_hit | local_hit);
    assign mmatch_out_n = ~((~upstream_hit & local_multi) | (upstream_hit & local_hit));
    assign full_out_n   = ~(upstream_full & local_full);
    assign chain_owner  = ~upstream_hit & local_hit;
    assign free_owner   = upstream_full & ~local_full;
endmodule

// File: rtl/cam_stack_slice.sv
module cam_stack_slice
    import cam_slice_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    parameter int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic [3:0]       op,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic             match_in_n,
    input  logic             full_in_n,
    output logic             match_out_n,
    output logic             full_out_n,
    output logic             mmatch_out_n,
    output logic [AW-1:0]    maddr,
    output logic             maddr_oe,
    output logic [WIDTH-1:0] rdata,
    output logic             rdata_oe
);
    localparam int STAT_USED = AW + 3;

    // Command capture while the strobe is low
    logic             en_n_q;
    cam_op_e          op_q;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] data_q;
    logic             commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_n_q <= 1'b1;
            op_q   <= OP_NOP;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            en_n_q <= en_n;
            if (!en_n) begin
                op_q   <= decode_op(op);
                addr_q <= addr;
                data_q <= din;
            end
        end
    end

    assign commit = en_n && !en_n_q;

    // Storage and search
    logic [ENTRIES-1:0] hit_vec, valid_vec;
    logic               hit_any, free_any, local_full;
    logic [AW-1:0]      hit_idx, free_idx, rd_idx, wr_idx;
    logic [WIDTH-1:0]   rd_word;
    logic               wr_en, clr_en;
    logic               chain_owner, free_owner;

    cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_hit_enc (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_free_enc (
        .req (~valid_vec),
        .any (free_any),
        .idx (free_idx)
    );

    assign local_full = ~free_any;

    // Stored compare results
    cam_flags_t    flags_q;
    logic [AW-1:0] hpm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            hpm_q   <= '0;
        end else if (commit && op_q == OP_CMP) begin
            flags_q.hit   <= hit_any;
            flags_q.multi <= ($countones(hit_vec) > 1);
            hpm_q         <= hit_idx;
        end
    end

    cam_cascade u_cascade (
        .match_in_n   (match_in_n),
        .full_in_n    (full_in_n),
        .local_hit    (flags_q.hit),
        .local_multi  (flags_q.multi),
        .local_full   (local_full),
        .match_out_n  (match_out_n),
        .full_out_n   (full_out_n),
        .mmatch_out_n (mmatch_out_n),
        .chain_owner  (chain_owner),
        .free_owner   (free_owner)
    );

    // Write / delete steering
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = addr_q;
        if (commit) begin
            case (op_q)
                OP_WR_AT:   wr_en = 1'b1;
                OP_WR_FREE: begin wr_en = free_owner;  wr_idx = free_idx; end
                OP_WR_HPM:  begin wr_en = chain_owner; wr_idx = hpm_q;    end
                default:    wr_en = 1'b0;
            endcase
        end
    end

    assign clr_en = commit && (op_q == OP_DEL);
    assign rd_idx = (op_q == OP_RD_HPM) ? hpm_q : addr_q;

    cam_match_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (data_q),
        .clr_en    (clr_en),
        .clr_idx   (addr_q),
        .key       (data_q),
        .rd_idx    (rd_idx),
        .rd_data   (rd_word),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec)
    );

    // Read return
    logic [WIDTH-1:0] stat_word;
    always_comb begin
        stat_word = '0;
        stat_word[STAT_USED-1:0] = {hpm_q, local_full, flags_q.multi, flags_q.hit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else if (commit) begin
            case (op_q)
                OP_RD_AT:   begin rdata <= rd_word;   rdata_oe <= 1'b1;        end
                OP_RD_HPM:  begin rdata <= rd_word;   rdata_oe <= chain_owner; end
                OP_RD_STAT: begin rdata <= stat_word; rdata_oe <= chain_owner; end
                default:    rdata_oe <= 1'b0;
            endcase
        end
    end

    assign maddr    = hpm_q;
    assign maddr_oe = chain_owner;

    // Checks next to the logic they guard
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_n |=> ($stable(flags_q) && $stable(hpm_q))); // R2
    AST_MM_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        !mmatch_out_n |-> !match_out_n); // R3
    AST_SINGLE_SERVER: assert property (@(posedge clk) disable iff (rst)
        maddr_oe |-> (match_in_n && !match_out_n)); // R4
    AST_FREE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (commit && op_q == OP_WR_FREE && full_in_n) |=> $stable(valid_vec)); // R5
    AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
        !full_out_n |-> !full_in_n); // R6
    AST_DEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (commit && op_q == OP_DEL) |=> !valid_vec[$past(addr_q)]); // R10
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (commit && op_q == OP_NOP) |=> ($stable(valid_vec) && !rdata_oe)); // R13
endmodule

// File: tb/cam_stack_slice_bench.sv
module cam_stack_slice_bench;
    localparam int N  = 16;
    localparam int W  = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_n = 1'b1;
    logic [3:0]    op = '0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic          match_in_n = 1'b1;
    logic          full_in_n = 1'b0;
    logic          match_out_n, full_out_n, mmatch_out_n, maddr_oe, rdata_oe;
    logic [AW-1:0] maddr;
    logic [W-1:0]  rdata;

    always #2 clk = ~clk;

    cam_stack_slice u_cam_stack_slice (
        .clk(clk), .rst(rst), .en_n(en_n), .op(op), .addr(addr), .din(din),
        .match_in_n(match_in_n), .full_in_n(full_in_n),
        .match_out_n(match_out_n), .full_out_n(full_out_n),
        .mmatch_out_n(mmatch_out_n), .maddr(maddr), .maddr_oe(maddr_oe),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_word [N];
    bit           m_valid [N];
    bit           m_hit, m_multi;
    int           m_idx;

    function automatic logic [W-1:0] pat(int i);
        return 32'h5A00_0000 | (i * 32'h0001_0203);
    endfunction

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(int code, int a, logic [W-1:0] d);
        @(negedge clk);
        op = 4'(code); addr = AW'(a); din = d; en_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic bit model_full();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_cmp(logic [W-1:0] key);
        int cnt = 0;
        m_idx = 0;
        for (int i = N - 1; i >= 0; i--)
            if (m_valid[i] && m_word[i] == key) begin cnt++; m_idx = i; end
        m_hit = (cnt > 0);
        m_multi = (cnt > 1);
    endtask

    task automatic cmp_check(logic [W-1:0] key, bit mi);
        match_in_n = mi;
        issue(1, 0, key);
        model_cmp(key);
        check(match_out_n == !(!mi || m_hit), "R1 match_out_n", W'(match_out_n), W'(!(!mi || m_hit)));
        check(maddr_oe == (mi && m_hit), "R4 maddr_oe", W'(maddr_oe), W'(mi && m_hit));
        check(mmatch_out_n == !((mi && m_multi) || (!mi && m_hit)), "R3 mmatch_out_n",
              W'(mmatch_out_n), W'(!((mi && m_multi) || (!mi && m_hit))));
        if (m_hit) check(maddr == AW'(m_idx), "R7 maddr", W'(maddr), W'(m_idx));
    endtask

    task automatic wr_free(logic [W-1:0] d, bit fi);
        full_in_n = fi;
        issue(3, 0, d);
        if (!fi && !model_full()) begin
            for (int i = 0; i < N; i++)
                if (!m_valid[i]) begin m_valid[i] = 1; m_word[i] = d; break; end
        end
    endtask

    task automatic rd_at_check(int a, bit mi, string req);
        match_in_n = mi;
        issue(7, a, '0);
        check(rdata_oe == 1'b1, req, W'(rdata_oe), 1);
        check(rdata == m_word[a], req, rdata, m_word[a]);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_word[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(match_out_n == 1'b1, "R12 match_out_n", W'(match_out_n), 1);
        check(full_out_n == 1'b1, "R12 full_out_n", W'(full_out_n), 1);
        check(mmatch_out_n == 1'b1, "R12 mmatch_out_n", W'(mmatch_out_n), 1);
        check(maddr_oe == 1'b0 && rdata_oe == 1'b0, "R12 oe", W'({maddr_oe, rdata_oe}), 0);
        match_in_n = 1'b0;
        #1 check(match_out_n == 1'b0, "R12 match follow", W'(match_out_n), 0);
        match_in_n = 1'b1;

        // R5 rejected when the full chain is not asserted
        wr_free(32'h1234_5678, 1'b1);
        cmp_check(32'h1234_5678, 1'b1);

        // R5 / R6 fill through write-next-free
        for (int i = 0; i < N; i++) begin
            wr_free(pat(i), 1'b0);
            check(full_out_n == !(i == N - 1), "R6 full_out_n", W'(full_out_n), W'(!(i == N - 1)));
        end
        full_in_n = 1'b1;
        #1 check(full_out_n == 1'b1, "R6 full_in high", W'(full_out_n), 1);
        wr_free(32'hDEAD_BEEF, 1'b0);
        cmp_check(32'hDEAD_BEEF, 1'b1); // R5 full slice rejects

        // R1 R3 R4 R7 sweep of all entries, both chain states
        for (int i = 0; i < N; i++) begin
            cmp_check(pat(i), 1'b1);
            cmp_check(pat(i), 1'b0);
        end

        // R9 duplicate planted by address write, read with chain asserted
        match_in_n = 1'b0;
        issue(2, 9, pat(3));
        m_word[9] = pat(3);
        rd_at_check(9, 1'b0, "R9 read at address");
        cmp_check(pat(3), 1'b1);
        cmp_check(pat(3), 1'b0);

        // R4 highest-priority read in both chain states
        match_in_n = 1'b1;
        issue(6, 0, '0);
        check(rdata_oe == 1'b1 && rdata == pat(3), "R4 read at match", rdata, pat(3));
        match_in_n = 1'b0;
        issue(6, 0, '0);
        check(rdata_oe == 1'b0, "R4 read gated", W'(rdata_oe), 0);

        // R11 status read
        match_in_n = 1'b1;
        issue(8, 0, '0);
        check(rdata == W'(32'd1 | 32'd2 | 32'd4 | (32'd3 << 3)), "R11 status", rdata, 32'h1F);
        match_in_n = 1'b0;
        issue(8, 0, '0);
        check(rdata_oe == 1'b0, "R11 status gated", W'(rdata_oe), 0);

        // R8 write at match, gated then allowed
        issue(5, 0, 32'hCAFE_0000);
        rd_at_check(3, 1'b0, "R8 gated write");
        match_in_n = 1'b1;
        cmp_check(pat(3), 1'b1);
        issue(5, 0, 32'hCAFE_0000);
        m_word[3] = 32'hCAFE_0000;
        rd_at_check(3, 1'b1, "R8 write at match");

        // R13 no-op leaves contents, drives read enable low
        issue(0, 3, 32'h0);
        check(rdata_oe == 1'b0, "R13 nop oe", W'(rdata_oe), 0);
        rd_at_check(3, 1'b1, "R13 nop contents");

        // R10 delete, then R5 refill of the hole
        issue(4, 5, '0);
        m_valid[5] = 0;
        cmp_check(pat(5), 1'b1);
        full_in_n = 1'b0;
        #1 check(full_out_n == 1'b1, "R6 hole opened", W'(full_out_n), 1);
        wr_free(32'h0BAD_F00D, 1'b0);
        cmp_check(32'h0BAD_F00D, 1'b1);
        check(maddr == AW'(5), "R5 lowest free entry", W'(maddr), 5);
        check(full_out_n == 1'b0, "R6 refilled", W'(full_out_n), 0);

        // R2 flags hold while strobe low
        cmp_check(pat(0), 1'b1);
        @(negedge clk);
        op = 4'd1; din = 32'hFFFF_FFFF; en_n = 1'b0;
        repeat (3) @(negedge clk);
        check(match_out_n == 1'b0 && maddr == '0, "R2 hold", W'({match_out_n, maddr}), 0);
        en_n = 1'b1;
        @(negedge clk);
        check(match_out_n == 1'b1, "R2 update", W'(match_out_n), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule